// File: doc/BRIEF.md
# Masked Match Table with Path Fallback

This block is a lookup table for the path and channel identifiers found in cell headers. It holds a parameterised number of 32-bit entries, and each entry has its own validity bit. A compare command presents a comparand. The block checks the comparand against every valid entry at once, optionally under a selectable bit mask. It returns the lowest-numbered matching entry, a flag saying the entry array hit, and a flag for multiple hits.

Beside the entry array sits a single-bit table with 2**SIDE_W locations. The upper SIDE_W comparand bits index it, and it is read in the same cycle as the compare. The table records path-only connections. Its bit decides the overall match only when no entry hits and the `side_en` control pin is high.

Commands enter on a valid/ready stream. Compares and side-table reads return one result on a second valid/ready stream. The result appears one cycle after the command is accepted. The block holds only one result. A command is accepted only while the result slot is empty or is being drained in the same cycle, so a stalled consumer stalls the command stream. A result stays unchanged until it is taken. Writes, validity updates, mask loads and side-table updates return no result.

Top module: `cam_lut`

## Requirements
- R1: After reset every entry is invalid, all mask registers hold zero, every side-table bit is 1, and `res_valid` is low. A compare issued right after reset reports no hit and `res_bit` = 1.
- R2: A write (op 0) to `cmd_addr` with `cmd_sel` = 0 replaces the whole entry. With `cmd_sel` = k (1..7), only the bit positions where mask register k is 0 take the new data, and the other bits keep their old value.
- R3: Op 1 marks entry `cmd_addr` valid and op 2 marks it invalid. Only valid entries can hit, and writing an entry does not change its validity.
- R4: A compare (op 4) with `cmd_sel` = k (1..7) ignores the bit positions where mask register k is 1. With `cmd_sel` = 0, all 32 bits must be equal.
- R5: On a hit, `res_addr` is the lowest-numbered hitting entry and `res_from_cam` is 1. On a miss, `res_addr` is 0 and `res_from_cam` is 0.
- R6: `res_multi` is 1 exactly when two or more valid entries hit.
- R7: On a compare, `res_bit` is the side-table bit at index `cmd_data[31:20]`. When no entry hits, `res_match` = 1 exactly when that bit is 0 and `side_en` is high. When an entry hits, `res_match` = 1 whatever the bit is.
- R8: Op 5 clears the side-table bit at index `cmd_data[31:20]` to 0, meaning a path match. Op 6 sets it to 1, meaning no match. Op 7 returns that bit on `res_bit`, with `res_match`, `res_from_cam`, `res_multi` and `res_addr` all 0.
- R9: While `side_en` is low during a compare, a side-table bit of 0 never produces `res_match` = 1 on its own.
- R10: `cmd_ready` is low only while a result is held and `res_ready` is low. A compare or side read accepted at a clock edge raises `res_valid` after that edge. A held result keeps all its fields until the cycle in which `res_ready` is high.
- R11: Op 3 loads `cmd_data` into mask register `cmd_sel` (1..7). Op 3 with `cmd_sel` = 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| side_en | input | 1 | Lets the side table supply a fallback match |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_op | input | 3 | Operation code (0..7, see R2–R11) |
| cmd_sel | input | 3 | Mask register select, or target register for op 3 |
| cmd_addr | input | AW | Entry address for write and validity operations |
| cmd_data | input | 32 | Write data, comparand, mask value or side-table index source |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_match | output | 1 | Overall match (entry hit or fallback) |
| res_from_cam | output | 1 | An entry hit |
| res_multi | output | 1 | More than one entry hit |
| res_addr | output | AW | Lowest hitting entry, 0 on a miss |
| res_bit | output | 1 | Side-table bit read by the command |

## Verification
Directed patterns come first. A comparand that equals an entry only when a mask hides its differing bits tells masked compares apart from unmasked ones. Two entries holding the same value tell the priority choice and the multiple-hit flag apart from a single hit. A comparand that misses the array but lands on a cleared side bit tells the fallback apart from an array hit, and also shows whether `side_en` gates it. A stalled result consumer tells whether results are held and whether commands are throttled. A long pseudo-random run of all eight operations, over a small address and value space, then mixes hits, misses, masks and stalls, and a behavioural model checks every cycle.

// File: rtl/cam_lut_pkg.sv
package cam_lut_pkg;
  typedef enum logic [2:0] {
    OP_WRITE     = 3'd0,
    OP_SET_VALID = 3'd1,
    OP_CLR_VALID = 3'd2,
    OP_LOAD_MASK = 3'd3,
    OP_COMPARE   = 3'd4,
    OP_SIDE_CLR  = 3'd5,
    OP_SIDE_SET  = 3'd6,
    OP_SIDE_READ = 3'd7
  } op_e;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
  parameter int ENTRIES = 64,
  parameter int DATA_W  = 32,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               set_vld,
  input  logic               clr_vld,
  input  logic [AW-1:0]      addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [DATA_W-1:0]  mask,     // 1 = keep on write, ignore on compare
  input  logic [DATA_W-1:0]  key,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [DATA_W-1:0] word_q;
    logic              used_q;
    logic              sel;
    assign sel = (addr == AW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
        used_q <= 1'b0;
      end else begin
        if (wr_en && sel) word_q <= (word_q & mask) | (wr_data & ~mask);
        if (set_vld && sel)      used_q <= 1'b1;
        else if (clr_vld && sel) used_q <= 1'b0;
      end
    end

    assign hit_vec[i] = used_q && (((word_q ^ key) & ~mask) == '0);
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 64,
  parameter int AW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic          multi,
  output logic [AW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = AW'(i);
    end
  end
  assign any   = |req;
  assign multi = |(req & (req - N'(1)));
endmodule

// File: rtl/side_bits.sv
module side_bits #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             wval,
  input  logic [IDX_W-1:0] idx,
  output logic             rbit
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  bits_q <= '1;
    else if (we) bits_q[idx] <= wval;
  end
  assign rbit = bits_q[idx];
endmodule

// File: rtl/cam_lut.sv
module cam_lut
  import cam_lut_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int DATA_W  = 32,
  parameter int SIDE_W  = 12,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              side_en,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [2:0]        cmd_sel,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_match,
  output logic              res_from_cam,
  output logic              res_multi,
  output logic [AW-1:0]     res_addr,
  output logic              res_bit
);
  localparam int SEL_W = 3;
  localparam int MASKS = (1 << SEL_W) - 1;

  logic              acc;
  logic [DATA_W-1:0] mask_q [1:MASKS];
  logic [DATA_W-1:0] sel_mask;
  logic [ENTRIES-1:0] hits;
  logic              hit_any, hit_multi, side_bit;
  logic [AW-1:0]     hit_idx;
  logic [SIDE_W-1:0] side_idx;

  assign cmd_ready = !res_valid || res_ready;
  assign acc       = cmd_valid && cmd_ready;
  assign side_idx  = cmd_data[DATA_W-1 -: SIDE_W];

  for (genvar m = 1; m <= MASKS; m++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n) mask_q[m] <= '0;
      else if (acc && cmd_op == OP_LOAD_MASK && cmd_sel == SEL_W'(m))
        mask_q[m] <= cmd_data;
    end
  end

  always_comb begin
    sel_mask = '0;
    for (int m = 1; m <= MASKS; m++) begin
      if (cmd_sel == SEL_W'(m)) sel_mask = mask_q[m];
    end
  end

  cam_store #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc && cmd_op == OP_WRITE),
    .set_vld (acc && cmd_op == OP_SET_VALID),
    .clr_vld (acc && cmd_op == OP_CLR_VALID),
    .addr    (cmd_addr),
    .wr_data (cmd_data),
    .mask    (sel_mask),
    .key     (cmd_data),
    .hit_vec (hits)
  );

  prio_pick #(.N(ENTRIES), .AW(AW)) u_pick (
    .req   (hits),
    .any   (hit_any),
    .multi (hit_multi),
    .idx   (hit_idx)
  );

  side_bits #(.IDX_W(SIDE_W)) u_side (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (acc && (cmd_op == OP_SIDE_CLR || cmd_op == OP_SIDE_SET)),
    .wval  (cmd_op == OP_SIDE_SET),
    .idx   (side_idx),
    .rbit  (side_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_match    <= 1'b0;
      res_from_cam <= 1'b0;
      res_multi    <= 1'b0;
      res_addr     <= '0;
      res_bit      <= 1'b0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (acc && cmd_op == OP_COMPARE) begin
        res_valid    <= 1'b1;
        res_from_cam <= hit_any;
        res_multi    <= hit_multi;
        res_addr     <= hit_idx;
        res_bit      <= side_bit;
        res_match    <= hit_any || (side_en && !side_bit);
      end else if (acc && cmd_op == OP_SIDE_READ) begin
        res_valid    <= 1'b1;
        res_from_cam <= 1'b0;
        res_multi    <= 1'b0;
        res_addr     <= '0;
        res_bit      <= side_bit;
        res_match    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cam_lut_chk.sv
module cam_lut_chk
  import cam_lut_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          side_en,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [2:0]    cmd_op,
  input logic          res_valid,
  input logic          res_ready,
  input logic          res_match,
  input logic          res_from_cam,
  input logic          res_multi,
  input logic [AW-1:0] res_addr,
  input logic          res_bit
);
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) && $stable(res_match)
      && $stable(res_from_cam) && $stable(res_multi) && $stable(res_bit)); // R10
  AST_COMPARE_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == OP_COMPARE |=> res_valid); // R10
  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_multi |-> res_from_cam); // R6
  AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_from_cam |-> res_match); // R7
  AST_FALLBACK_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_match && !res_from_cam |-> !res_bit); // R7
  AST_FALLBACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == OP_COMPARE && !side_en
      |=> !(res_match && !res_from_cam)); // R9
  AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_from_cam |-> res_addr == '0); // R5
endmodule

bind cam_lut cam_lut_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .side_en      (side_en),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_op       (cmd_op),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_match    (res_match),
  .res_from_cam (res_from_cam),
  .res_multi    (res_multi),
  .res_addr     (res_addr),
  .res_bit      (res_bit)
);

// File: tb/test_cam_lut.sv
module test_cam_lut;
  localparam int ENT = 64;
  localparam int AW  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        side_en = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_sel = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [31:0] cmd_data = '0;
  logic        res_valid, res_ready = 1'b1;
  logic        res_match, res_from_cam, res_multi, res_bit;
  logic [AW-1:0] res_addr;

  always #5 clk = ~clk;

  cam_lut i_cam_lut (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_e [ENT];
  bit          m_v [ENT];
  logic [31:0] m_mask [8];
  bit          m_side [4096];
  bit          m_rv, m_acc;
  logic [9:0]  m_res;   // {match, from_cam, multi, addr[6], bit}
  string       m_tag = "R1", cur_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) begin m_e[i] = 0; m_v[i] = 0; end
      for (int i = 0; i < 8; i++) m_mask[i] = 0;
      for (int i = 0; i < 4096; i++) m_side[i] = 1;
      m_rv = 0; m_acc = 0; m_res = 0;
    end else begin
      logic [31:0] mk;
      int idx, cnt, sx;
      m_acc = cmd_valid && (!m_rv || res_ready);
      if (m_rv && res_ready) m_rv = 0;
      mk = (cmd_sel == 0) ? 32'h0 : m_mask[cmd_sel];
      sx = int'(cmd_data[31:20]);
      if (m_acc) begin
        case (cmd_op)
          3'd0: m_e[cmd_addr] = (m_e[cmd_addr] & mk) | (cmd_data & ~mk);
          3'd1: m_v[cmd_addr] = 1;
          3'd2: m_v[cmd_addr] = 0;
          3'd3: if (cmd_sel != 0) m_mask[cmd_sel] = cmd_data;
          3'd4: begin
            cnt = 0; idx = 0;
            for (int e = ENT - 1; e >= 0; e--)
              if (m_v[e] && (((m_e[e] ^ cmd_data) & ~mk) == 0)) begin cnt++; idx = e; end
            m_res = {(cnt > 0) || (side_en && !m_side[sx]), cnt > 0, cnt > 1,
                     AW'(idx), m_side[sx]};
            m_rv = 1; m_tag = cur_tag;
          end
          3'd5: m_side[sx] = 0;
          3'd6: m_side[sx] = 1;
          default: begin
            m_res = {4'b0, AW'(0), m_side[sx]};
            m_rv = 1; m_tag = cur_tag;
          end
        endcase
      end
    end
  end

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #3;
    if (!done) begin
      logic [9:0] act;
      total++;
      if (res_valid !== (rst_n && m_rv)) begin
        bad++; $display("FAIL %s res_valid act=%b exp=%b", rst_n ? "R10" : "R1", res_valid, m_rv);
      end
      total++;
      if (cmd_ready !== (!m_rv || res_ready)) begin
        bad++; $display("FAIL R10 cmd_ready act=%b exp=%b", cmd_ready, !m_rv || res_ready);
      end
      if (rst_n && m_rv) begin
        act = {res_match, res_from_cam, res_multi, res_addr, res_bit};
        total++;
        if (act !== m_res) begin
          bad++; $display("FAIL %s result act=%h exp=%h", m_tag, act, m_res);
        end
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [2:0] sel,
                       input int addr, input logic [31:0] data, input string tag);
    int n = 0;
    @(negedge clk);
    cmd_op = op; cmd_sel = sel; cmd_addr = AW'(addr); cmd_data = data;
    cmd_valid = 1; cur_tag = tag;
    do begin
      @(posedge clk); #1;
      if (!m_acc) begin
        n++;
        if (n > 2) begin @(negedge clk); res_ready = 1; end
      end
    end while (!m_acc);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] s = 32'h1ACE_5EED;
    repeat (3) @(negedge clk);
    rst_n = 1;
    issue(3'd4, 0, 0, 32'h0, "R1");                 // miss, bit 1
    issue(3'd0, 0, 3, 32'hA5A5_0F0F, "R2");
    issue(3'd1, 0, 3, 0, "R3");
    issue(3'd4, 0, 0, 32'hA5A5_0F0F, "R2");         // hit 3
    issue(3'd3, 1, 0, 32'h0000_FFFF, "R11");
    issue(3'd3, 0, 0, 32'hFFFF_FFFF, "R11");        // no effect
    issue(3'd0, 1, 3, 32'h1234_5678, "R2");         // -> 1234_0F0F
    issue(3'd4, 0, 0, 32'h1234_0F0F, "R2");
    issue(3'd4, 0, 0, 32'h1234_5678, "R2");         // miss
    issue(3'd2, 0, 3, 0, "R3");
    issue(3'd4, 0, 0, 32'h1234_0F0F, "R3");         // miss, invalid
    issue(3'd1, 0, 3, 0, "R3");
    issue(3'd3, 2, 0, 32'hFF00_0000, "R4");
    issue(3'd4, 2, 0, 32'h0034_0F0F, "R4");         // masked hit
    issue(3'd4, 0, 0, 32'h0034_0F0F, "R4");         // miss
    issue(3'd0, 0, 20, 32'hCAFE_0001, "R6");
    issue(3'd1, 0, 20, 0, "R6");
    issue(3'd0, 0, 10, 32'hCAFE_0001, "R5");
    issue(3'd1, 0, 10, 0, "R5");
    issue(3'd4, 0, 0, 32'hCAFE_0001, "R6");         // addr 10, multi
    issue(3'd2, 0, 10, 0, "R5");
    issue(3'd4, 0, 0, 32'hCAFE_0001, "R5");         // addr 20 single
    issue(3'd5, 0, 0, 32'h1230_0000, "R8");
    issue(3'd7, 0, 0, 32'h123F_FFFF, "R8");         // bit 0
    issue(3'd4, 0, 0, 32'h1230_0001, "R7");         // fallback match
    issue(3'd0, 0, 5, 32'h1230_0001, "R7");
    issue(3'd1, 0, 5, 0, "R7");
    issue(3'd4, 0, 0, 32'h1230_0001, "R7");         // cam hit wins
    side_en = 0;
    issue(3'd4, 0, 0, 32'h1230_0007, "R9");         // no fallback
    side_en = 1;
    issue(3'd6, 0, 0, 32'h1230_0000, "R8");
    issue(3'd7, 0, 0, 32'h1230_0000, "R8");         // bit 1
    issue(3'd4, 0, 0, 32'h1230_0007, "R7");         // miss
    @(negedge clk); res_ready = 0;
    issue(3'd4, 0, 0, 32'hCAFE_0001, "R10");
    issue(3'd4, 0, 0, 32'h1234_0F0F, "R10");        // stalled, then released
    for (int k = 0; k < 400; k++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      @(negedge clk);
      res_ready = s[20] | s[21];
      side_en   = s[22] | s[23];
      issue(s[2:0], s[5:3], int'(s[8:6]),
            {s[11:9], 25'd0, s[15:12]} | (s[27] ? 32'h0 : {28'd0, s[19:16]}), "R4");
    end
    @(negedge clk); res_ready = 1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule